// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt request positions into a sticky pending register, qualifies them with a mask and a global enable, and hands the most urgent one to a core as a one-cycle acknowledge plus a vector address. Positions 0 (reset) and 1 (power-down) are nonmaskable. Position 2 is the stack-level request, position 3 is the emulation-kernel request, and positions 4 to 15 are user positions.

Fifteen peripheral sources reach the user positions through a 4-bit priority level kept for each source. Level p drives position p+4. Every level of 11 or above lands on position 15, so those sources share its vector. Software writes through a small register port. With it, software programs the mask, the control bits and the priority levels, and forces or cancels pending bits. A return pulse from the core retires the active level. This makes room for the next acknowledge, either one at a time or nested by strict priority.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pending bit is set by its hardware request line or by writing a 1 at that bit position to address 2 (force). It holds until it is acknowledged or until a 1 is written at that position to address 3 (cancel). A request or force in the same cycle wins over a cancel.
- R2: The eligible set is the pending register ANDed with the mask register (address 0, 1 = enabled, reset 0x0000), where bits 0 and 1 ignore the mask. The lowest-numbered eligible bit is chosen.
- R3: At the first clock edge where a bit is chosen and accepted, `irq_ack` rises for exactly one cycle. At that same edge `irq_vec` becomes index × 0x20 (0x000 to 0x1E0) and the chosen pending bit clears. A request written or latched at edge e is therefore acknowledged at edge e+1.
- R4: The control register sits at address 1, with bit 5 as global enable and bit 4 as nesting enable, and is cleared by reset. While global enable is 0, only bit 0 can be acknowledged; bit 1 is blocked too.
- R5: Peripheral source s with level p sets pending bit min(p,11)+4. Sources on the same level are ORed into one bit.
- R6: The level of source s is field s mod 4 (bits 4·(s mod 4)+3 down to 4·(s mod 4)) of address 4 + s/4. After reset, sources 0 to 10 hold levels 0 to 10 and sources 11 to 14 hold level 11.
- R7: With nesting disabled, no acknowledge is issued while any bit of `active_o` is set. An `rti` pulse clears the lowest-numbered bit of `active_o`.
- R8: With nesting enabled, a chosen bit is accepted only if its index is below the lowest-numbered active bit. Each acknowledge sets its bit in `active_o`.
- R9: After reset, the pending register, `active_o` and `irq_ack` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | 4 | Request lines for positions 0 to 3 |
| periph_req | input | 15 | Peripheral request lines, one per source |
| rti | input | 1 | Return-from-interrupt pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| irq_ack | output | 1 | One-cycle acknowledge |
| irq_vec | output | 9 | Vector address of the last acknowledge |
| pend_o | output | 16 | Pending register |
| active_o | output | 16 | In-service levels |

## Verification
A write or request line applied before edge e shows up in `pend_o` after edge e. The acknowledge for it appears after edge e+1, and the pending bit clears at that same edge. An `rti` pulse at edge r changes `active_o` after r, and any acknowledge it frees comes after r+1. All inputs are driven at falling edges and every result is sampled at the falling edge that follows the edge on which it is due. The nesting sequences check for the absence of an acknowledge at the edge where one would appear if the block ignored the blocking rule.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NLINES    = 16;
    localparam int IDX_W     = $clog2(NLINES);
    localparam int STRIDE_SH = 5;
    localparam int VEC_W     = IDX_W + STRIDE_SH;
    localparam int NSRC      = 15;
    localparam int PRIO_W    = 4;
    localparam int USER_BASE = 4;
    localparam int TOP_LVL   = NLINES - USER_BASE - 1;
    localparam int NLVL      = TOP_LVL + 1;
    localparam int AW        = 3;
    localparam int DW        = NLINES;
    localparam int FLD_PER_W = DW / PRIO_W;

    localparam logic [AW-1:0] A_MASK  = 3'd0;
    localparam logic [AW-1:0] A_CTRL  = 3'd1;
    localparam logic [AW-1:0] A_SET   = 3'd2;
    localparam logic [AW-1:0] A_CLR   = 3'd3;
    localparam int            A_PRIO0 = 4;

    localparam int CTRL_NEST_BIT = 4;
    localparam int CTRL_GIE_BIT  = 5;

    localparam logic [NLINES-1:0] NMI_BITS = NLINES'(2'b11);
    localparam logic [NLINES-1:0] GIE_OFF_ALLOW = NLINES'(1);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic nest;
        logic gie;
    } ctrl_t;

    function automatic pick_t first_set(input logic [NLINES-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [PRIO_W-1:0] fold_lvl(input logic [PRIO_W-1:0] p);
        return (p > PRIO_W'(TOP_LVL)) ? PRIO_W'(TOP_LVL) : p;
    endfunction

    function automatic logic [PRIO_W-1:0] reset_lvl(input int src);
        return (src < TOP_LVL) ? PRIO_W'(src) : PRIO_W'(TOP_LVL);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return {idx, {STRIDE_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_vec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic [NLINES-1:0]      mask_q,
    output ctrl_t                  ctrl_q,
    output logic [NSRC*PRIO_W-1:0] prio_q,
    output logic [NLINES-1:0]      sw_set,
    output logic [NLINES-1:0]      sw_clr
);
    always_comb begin
        sw_set = (wr_en && wr_addr == A_SET) ? wr_data : '0;
        sw_clr = (wr_en && wr_addr == A_CLR) ? wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MASK) mask_q <= wr_data;
            if (wr_addr == A_CTRL) begin
                ctrl_q.nest <= wr_data[CTRL_NEST_BIT];
                ctrl_q.gie  <= wr_data[CTRL_GIE_BIT];
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_prio
        localparam logic [AW-1:0] MY_ADDR = AW'(A_PRIO0 + s / FLD_PER_W);
        localparam int            MY_LSB  = (s % FLD_PER_W) * PRIO_W;
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[s*PRIO_W +: PRIO_W] <= reset_lvl(s);
            else if (wr_en && wr_addr == MY_ADDR)
                prio_q[s*PRIO_W +: PRIO_W] <= wr_data[MY_LSB +: PRIO_W];
        end
    end
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_vec_pkg::*;
(
    input  logic [NSRC-1:0]        periph_req,
    input  logic [NSRC*PRIO_W-1:0] prio_q,
    output logic [NLVL-1:0]        lvl_req
);
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        always_comb begin
            lvl_req[l] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (periph_req[s] && fold_lvl(prio_q[s*PRIO_W +: PRIO_W]) == PRIO_W'(l))
                    lvl_req[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] hw_req,
    input  logic [NLINES-1:0] sw_set,
    input  logic [NLINES-1:0] sw_clr,
    input  logic [NLINES-1:0] mask_q,
    input  ctrl_t             ctrl_q,
    input  logic              rti,
    output logic              ack_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [NLINES-1:0] latch_q,
    output logic [NLINES-1:0] isr_q
);
    logic [NLINES-1:0] eligible;
    logic [NLINES-1:0] ack_oh;
    logic [NLINES-1:0] rti_oh;
    pick_t             pick;
    pick_t             top_active;
    logic              accept;

    always_comb begin
        eligible   = latch_q & (mask_q | NMI_BITS) & (ctrl_q.gie ? '1 : GIE_OFF_ALLOW);
        pick       = first_set(eligible);
        top_active = first_set(isr_q);
        if (!pick.valid)
            accept = 1'b0;
        else if (!top_active.valid)
            accept = 1'b1;
        else
            accept = ctrl_q.nest && (pick.idx < top_active.idx);
        ack_oh = accept ? (NLINES'(1) << pick.idx) : '0;
        rti_oh = (rti && top_active.valid) ? (NLINES'(1) << top_active.idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            isr_q   <= '0;
            ack_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            latch_q <= (latch_q & ~sw_clr & ~ack_oh) | hw_req | sw_set;
            isr_q   <= (isr_q & ~rti_oh) | ack_oh;
            ack_q   <= accept;
            if (accept) vec_q <= vec_of(pick.idx);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [USER_BASE-1:0] sys_req,
    input  logic [NSRC-1:0]   periph_req,
    input  logic              rti,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              irq_ack,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [NLINES-1:0] pend_o,
    output logic [NLINES-1:0] active_o
);
    logic [NLINES-1:0]      mask_w;
    ctrl_t                  ctrl_w;
    logic [NSRC*PRIO_W-1:0] prio_w;
    logic [NLINES-1:0]      set_w;
    logic [NLINES-1:0]      clr_w;
    logic [NLVL-1:0]        lvl_w;
    logic [NLINES-1:0]      hw_w;
    logic                   gie_w;
    logic                   nest_w;

    irq_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_q(mask_w), .ctrl_q(ctrl_w), .prio_q(prio_w), .sw_set(set_w), .sw_clr(clr_w)
    );

    irq_src_map u_map (
        .periph_req(periph_req), .prio_q(prio_w), .lvl_req(lvl_w)
    );

    assign hw_w   = {lvl_w, sys_req};
    assign gie_w  = ctrl_w.gie;
    assign nest_w = ctrl_w.nest;

    irq_arbiter u_arb (
        .clk(clk), .rst(rst), .hw_req(hw_w), .sw_set(set_w), .sw_clr(clr_w),
        .mask_q(mask_w), .ctrl_q(ctrl_w), .rti(rti),
        .ack_q(irq_ack), .vec_q(irq_vec), .latch_q(pend_o), .isr_q(active_o)
    );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_ack,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [NLINES-1:0] active_o,
    input logic [NLINES-1:0] mask_w,
    input logic              gie_w,
    input logic              nest_w
);
    assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> irq_vec[STRIDE_SH-1:0] == '0);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !nest_w && !$past(nest_w)) |=> !irq_ack);

    assert_gie_block_R4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> ($past(gie_w) || irq_vec == '0));

    assert_mask_honoured_R2: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (irq_vec[VEC_W-1:STRIDE_SH] < IDX_W'(2)
                     || (($past(mask_w) >> irq_vec[VEC_W-1:STRIDE_SH]) & NLINES'(1)) != '0));

    assert_no_nest_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !$past(nest_w)) |-> $past(active_o) == '0);

    assert_active_marked_R8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> ((active_o >> irq_vec[VEC_W-1:STRIDE_SH]) & NLINES'(1)) != '0);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_vec(irq_vec), .active_o(active_o),
    .mask_w(mask_w), .gie_w(gie_w), .nest_w(nest_w)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sys_req = '0;
    logic [14:0] periph_req = '0;
    logic        rti = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq_ack;
    logic [8:0]  irq_vec;
    logic [15:0] pend_o;
    logic [15:0] active_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .sys_req(sys_req), .periph_req(periph_req), .rti(rti),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ack(irq_ack), .irq_vec(irq_vec), .pend_o(pend_o), .active_o(active_o)
    );

    typedef struct packed {
        logic [15:0] mask;
        logic [15:0] ctrl;
        logic [15:0] force_bits;
        logic        ack;
        logic [8:0]  vec;
        logic [15:0] pend;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{16'hFFFF, 16'h0020, 16'h0030, 1'b1, 9'h080, 16'h0020},
        '{16'h0000, 16'h0020, 16'h0F00, 1'b0, 9'h000, 16'h0F00},
        '{16'h0000, 16'h0020, 16'h0002, 1'b1, 9'h020, 16'h0000},
        '{16'hFFFF, 16'h0000, 16'h0002, 1'b0, 9'h000, 16'h0002},
        '{16'h0000, 16'h0000, 16'h0001, 1'b1, 9'h000, 16'h0000},
        '{16'h8000, 16'h0020, 16'hC000, 1'b1, 9'h1E0, 16'h4000},
        '{16'hFFFF, 16'h0020, 16'h000C, 1'b1, 9'h040, 16'h0008},
        '{16'hFF00, 16'h0020, 16'h0A80, 1'b1, 9'h120, 16'h0880}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_periph(input logic [14:0] p);
        @(negedge clk); periph_req = p;
        @(negedge clk); periph_req = '0;
    endtask

    task automatic pulse_rti();
        @(negedge clk); rti = 1'b1;
        @(negedge clk); rti = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // R9 reset state
        do_reset();
        chk("R9 ack", 32'(irq_ack), 0);
        chk("R9 pend", 32'(pend_o), 0);
        chk("R9 active", 32'(active_o), 0);

        // Vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd0, VT[i].mask);
            wr(3'd1, VT[i].ctrl);
            wr(3'd2, VT[i].force_bits);
            @(negedge clk);
            chk($sformatf("R2 R3 R4 vec%0d ack", i), 32'(irq_ack), 32'(VT[i].ack));
            if (VT[i].ack) chk($sformatf("R3 vec%0d vector", i), 32'(irq_vec), 32'(VT[i].vec));
            chk($sformatf("R1 vec%0d pend", i), 32'(pend_o), 32'(VT[i].pend));
        end

        // R5 peripheral with reset level 3 -> bit 7
        do_reset();
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'h0020);
        pulse_periph(15'h0008);
        chk("R5 periph3 latched", 32'(pend_o), 32'h0080);
        @(negedge clk);
        chk("R5 periph3 ack", 32'(irq_ack), 1);
        chk("R5 periph3 vec", 32'(irq_vec), 32'h0E0);

        // R5 R6 sources 12 and 13 share bit 15
        do_reset();
        wr(3'd0, 16'hFFFF);
        pulse_periph(15'h3000);
        chk("R5 R6 alias pend", 32'(pend_o), 32'h8000);
        wr(3'd1, 16'h0020);
        @(negedge clk);
        chk("R5 alias ack", 32'(irq_ack), 1);
        chk("R5 alias vec", 32'(irq_vec), 32'h1E0);
        chk("R5 alias pend cleared", 32'(pend_o), 0);

        // R6 reprogram levels, R1 cancel
        do_reset();
        wr(3'd7, 16'h0BB0);
        pulse_periph(15'h1000);
        chk("R6 src12 level0", 32'(pend_o), 32'h0010);
        wr(3'd4, 16'h321D);
        pulse_periph(15'h0001);
        chk("R6 src0 level13 folds", 32'(pend_o), 32'h8010);
        wr(3'd3, 16'h0010);
        chk("R1 cancel", 32'(pend_o), 32'h8000);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h0004; sys_req = 4'h4;
        @(negedge clk); wr_en = 1'b0; sys_req = '0;
        chk("R1 request beats cancel", 32'(pend_o), 32'h8004);

        // R7 nesting disabled
        do_reset();
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'h0020);
        wr(3'd2, 16'h0100);
        @(negedge clk);
        chk("R7 first ack vec", 32'(irq_vec), 32'h100);
        @(negedge clk);
        chk("R3 ack one cycle", 32'(irq_ack), 0);
        wr(3'd2, 16'h0010);
        @(negedge clk);
        chk("R7 blocked ack", 32'(irq_ack), 0);
        chk("R7 blocked pend", 32'(pend_o), 32'h0010);
        pulse_rti();
        chk("R7 rti clears active", 32'(active_o), 0);
        chk("R7 no ack at rti edge", 32'(irq_ack), 0);
        @(negedge clk);
        chk("R7 ack after rti", 32'(irq_ack), 1);
        chk("R7 vec after rti", 32'(irq_vec), 32'h080);

        // R8 nesting enabled
        do_reset();
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'h0030);
        wr(3'd2, 16'h0100);
        @(negedge clk);
        chk("R8 first ack", 32'(irq_ack), 1);
        wr(3'd2, 16'h0400);
        @(negedge clk);
        chk("R8 lower not preempting", 32'(irq_ack), 0);
        wr(3'd2, 16'h0020);
        @(negedge clk);
        chk("R8 preempt ack", 32'(irq_ack), 1);
        chk("R8 preempt vec", 32'(irq_vec), 32'h0A0);
        chk("R8 active two", 32'(active_o), 32'h0120);
        pulse_rti();
        chk("R8 rti retires bit5", 32'(active_o), 32'h0100);
        chk("R8 still blocked", 32'(irq_ack), 0);
        pulse_rti();
        chk("R8 all retired", 32'(active_o), 0);
        @(negedge clk);
        chk("R8 pending lower ack", 32'(irq_ack), 1);
        chk("R8 pending lower vec", 32'(irq_vec), 32'h140);

        summary();
    end
endmodule